// File: doc/BRIEF.md
# Periodic Pulse Pattern Generator

This block turns a bit pattern held in memory into a train of timing strobes. Each of three independent channels (trigger, veto and sweep) owns a 1024-location, 1-bit pattern memory. A host register port writes and reads each memory as 64 words of 16 bits. A second, read-only port scans the memory, and each location it reaches can raise that channel's output strobe. Downstream digitizers use these strobes to capture pedestal (baseline) samples at regular intervals that have no relation to detector activity.

The scan address comes from one of two sources. The first is an internal counter that steps at a decade rate from 1 Hz to 100 kHz, taken from a chain of divide-by-ten prescalers. The second is an external 10-bit address input. All three channels share one scan address, so a bit set at the same location in several memories fires those channels together. Setting every Nth bit of a pattern gives a strobe every N steps.

The host port and the scan controls are plain register-style pins. Host writes take effect at the next clock edge and cannot be stalled. Read data is registered and appears one cycle after the read request. The block has no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `pulse_pattern_gen`

## Requirements
- R1: After reset the scan address is 0, all strobe outputs are 0, host read data is 0 and every pattern bit is 0.
- R2: A host write of word k on channel c stores bit j of the written data at pattern location 16*k + j of that channel, so bit 0 lands at the lowest location. A host read of word k returns those 16 bits on host_rdata, registered one cycle after the request.
- R3: A host channel index of 3 or above selects no memory. A write with such an index changes no pattern, and a read with such an index returns 0.
- R4: With src_ext = 0 the scan address advances by exactly one on each step of the selected rate. It wraps from 1023 to 0 and does not change between steps.
- R5: rate_sel = r, for r from 0 to 5, sets a step period of 10^(5-r) base ticks: 0 gives 1 Hz and 5 gives 100 kHz. One base tick lasts CLK_HZ/FAST_HZ clock cycles. The codes 6 and 7 behave like 5.
- R6: A cycle with cnt_clear = 1 sets the scan address to 0 and restarts the rate divider. No step and no strobe come from that cycle. The first step after it occurs exactly one step period after the clear edge.
- R7: With src_ext = 1 (and cnt_clear = 0) the scan address loads ext_addr on every edge. A step is counted only when the loaded value differs from the previous address, so an address held steady raises no further strobe.
- R8: pulse_out[c] is a registered strobe. It is 1 for exactly the one cycle after a step has moved the scan address to a location whose bit is set in channel c's pattern, and 0 otherwise. Channels 0, 1 and 2 (trigger, veto, sweep) are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Write host_wdata to the selected pattern word |
| host_rd_en | input | 1 | Load the selected pattern word into host_rdata |
| host_ch | input | 2 | Channel index: 0 trigger, 1 veto, 2 sweep |
| host_word | input | 6 | Word index within the pattern (16 locations per word) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| rate_sel | input | 3 | Step rate code for the internal counter |
| src_ext | input | 1 | 0 = internal counter, 1 = external address |
| ext_addr | input | 10 | External scan address |
| cnt_clear | input | 1 | Synchronous clear of the scan address and the divider |
| scan_addr | output | 10 | Current scan address |
| pulse_out | output | 3 | Per-channel strobe (0 trigger, 1 veto, 2 sweep) |

## Verification
Each channel is loaded with a different pattern that is computed arithmetically, so a bit crossed between channels or a word mapped to the wrong location shows up as a mismatch. The readback covers all 192 words. The internal counter sweeps past the 1023-to-0 wrap at the fastest rate, which checks every location of all three patterns in turn. Slower sweeps at periods of 10 and 1000 steps, plus an out-of-range rate code, separate a wrong prescaler tap from an off-by-one in the first step after a clear. External-address runs include held and repeated values, which show whether the strobe comes from a change of address or from the address level itself.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int DIGIT_W  = 4;
  localparam logic [DIGIT_W-1:0] DEC_LAST = 4'd9;
  localparam int NUM_PAT  = 3;
  typedef enum logic [1:0] {
    CH_TRIGGER = 2'd0,
    CH_VETO    = 2'd1,
    CH_SWEEP   = 2'd2
  } pat_ch_e;
endpackage

// File: rtl/ppg_decade_div.sv
module ppg_decade_div
  import ppg_pkg::*;
#(
  parameter int BASE_DIV = 500,
  parameter int NUM_DEC  = 6,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             step
);
  localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1;

  logic [NUM_DEC-1:0] tick;

  generate
    if (BASE_DIV <= 1) begin : g_base_direct
      assign tick[0] = 1'b1;
    end else begin : g_base_count
      localparam int BW = $clog2(BASE_DIV);
      localparam logic [BW-1:0] BLAST = BW'(BASE_DIV - 1);
      logic [BW-1:0] bcnt;
      always_ff @(posedge clk) begin
        if (!rst_n || clear)  bcnt <= '0;
        else if (bcnt == BLAST) bcnt <= '0;
        else                  bcnt <= bcnt + 1'b1;
      end
      assign tick[0] = (bcnt == BLAST);
    end

    for (genvar i = 0; i < NUM_DEC - 1; i++) begin : g_stage
      logic [DIGIT_W-1:0] dcnt;
      always_ff @(posedge clk) begin
        if (!rst_n || clear) dcnt <= '0;
        else if (tick[i])    dcnt <= (dcnt == DEC_LAST) ? '0 : dcnt + 1'b1;
      end
      assign tick[i+1] = tick[i] && (dcnt == DEC_LAST);
    end
  endgenerate

  logic [IDX_W-1:0] sel_idx;
  always_comb begin
    sel_idx = IDX_W'(0);
    if (int'(rate_sel) < NUM_DEC) sel_idx = IDX_W'(NUM_DEC - 1 - int'(rate_sel));
    step = tick[sel_idx];
  end
endmodule

// File: rtl/ppg_addr_gen.sv
module ppg_addr_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              src_ext,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              moved
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      addr  <= '0;
      moved <= 1'b0;
    end else if (src_ext) begin
      addr  <= ext_addr;
      moved <= (ext_addr != addr);
    end else begin
      moved <= step;
      if (step) addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/ppg_pattern_mem.sv
module ppg_pattern_mem #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-$clog2(WORD_W)-1:0] word_idx,
  input  logic [WORD_W-1:0]                wdata,
  output logic [WORD_W-1:0]                word_out,
  input  logic [ADDR_W-1:0]                scan_addr,
  output logic                             scan_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (!rst_n)     bits <= '0;
    else if (wr_en) bits[word_idx*WORD_W +: WORD_W] <= wdata;
  end

  assign word_out = bits[word_idx*WORD_W +: WORD_W];
  assign scan_bit = bits[scan_addr];
endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen
  import ppg_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int FAST_HZ = 100_000,
  parameter int NUM_DEC = 6,
  parameter int RATE_W  = 3,
  parameter int ADDR_W  = 10,
  parameter int WORD_W  = 16,
  parameter int NUM_CH  = NUM_PAT,
  parameter int CH_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             host_wr_en,
  input  logic                             host_rd_en,
  input  logic [CH_W-1:0]                  host_ch,
  input  logic [ADDR_W-$clog2(WORD_W)-1:0] host_word,
  input  logic [WORD_W-1:0]                host_wdata,
  output logic [WORD_W-1:0]                host_rdata,
  input  logic [RATE_W-1:0]                rate_sel,
  input  logic                             src_ext,
  input  logic [ADDR_W-1:0]                ext_addr,
  input  logic                             cnt_clear,
  output logic [ADDR_W-1:0]                scan_addr,
  output logic [NUM_CH-1:0]                pulse_out
);
  localparam int BASE_DIV = (CLK_HZ / FAST_HZ < 1) ? 1 : CLK_HZ / FAST_HZ;

  logic step;
  logic moved;
  logic [NUM_CH-1:0] scan_bits;
  logic [WORD_W-1:0] words [NUM_CH];

  ppg_decade_div #(
    .BASE_DIV(BASE_DIV), .NUM_DEC(NUM_DEC), .SEL_W(RATE_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear),
    .rate_sel(rate_sel), .step(step)
  );

  ppg_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .step(step),
    .src_ext(src_ext), .ext_addr(ext_addr),
    .addr(scan_addr), .moved(moved)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic we;
      assign we = host_wr_en && (int'(host_ch) == c);

      ppg_pattern_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .word_idx(host_word),
        .wdata(host_wdata), .word_out(words[c]),
        .scan_addr(scan_addr), .scan_bit(scan_bits[c])
      );

      always_ff @(posedge clk) begin
        if (!rst_n) pulse_out[c] <= 1'b0;
        else        pulse_out[c] <= moved && scan_bits[c];
      end
    end
  endgenerate

  logic [WORD_W-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (int'(host_ch) == c) rd_sel = words[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          host_rdata <= '0;
    else if (host_rd_en) host_rdata <= rd_sel;
  end
endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16,
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd_en,
  input logic [CH_W-1:0]   host_ch,
  input logic [WORD_W-1:0] host_rdata,
  input logic              src_ext,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              cnt_clear,
  input logic [ADDR_W-1:0] scan_addr,
  input logic [NUM_CH-1:0] pulse_out
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> scan_addr == '0);

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_ext && !cnt_clear) |=>
      (scan_addr == $past(scan_addr) || scan_addr == ADDR_W'($past(scan_addr) + 1'b1)));

  assert_ext_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ext && !cnt_clear) |=> scan_addr == $past(ext_addr));

  assert_bad_ch_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && int'(host_ch) >= NUM_CH) |=> host_rdata == '0);

  assert_pulse_after_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && pulse_out != '0) |-> $past(scan_addr, 1) != $past(scan_addr, 2));
endmodule

bind pulse_pattern_gen ppg_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_CH(NUM_CH), .CH_W(CH_W)
) u_ppg_chk (
  .clk(clk), .rst_n(rst_n), .host_rd_en(host_rd_en), .host_ch(host_ch),
  .host_rdata(host_rdata), .src_ext(src_ext), .ext_addr(ext_addr),
  .cnt_clear(cnt_clear), .scan_addr(scan_addr), .pulse_out(pulse_out)
);

// File: tb/tb_pulse_pattern_gen.sv
`timescale 1ns/1ps
module tb_pulse_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [1:0]  host_ch = '0;
  logic [5:0]  host_word = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [2:0]  rate_sel = 3'd5;
  logic        src_ext = 1'b0;
  logic [9:0]  ext_addr = '0;
  logic        cnt_clear = 1'b0;
  logic [9:0]  scan_addr;
  logic [2:0]  pulse_out;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pulse_pattern_gen #(.CLK_HZ(100_000), .FAST_HZ(100_000)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_ch(host_ch), .host_word(host_word), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rate_sel(rate_sel), .src_ext(src_ext),
    .ext_addr(ext_addr), .cnt_clear(cnt_clear), .scan_addr(scan_addr),
    .pulse_out(pulse_out)
  );

  function automatic logic [15:0] pat(int c, int k);
    return 16'((k * 40503 + c * 7919 + 1) ^ (k << 3) ^ (c << 11));
  endfunction

  function automatic logic exp_bit(int c, int a);
    logic [15:0] w = pat(c, a / 16);
    return w[a % 16];
  endfunction

  function automatic logic [2:0] exp_pulse(int a);
    return {exp_bit(2, a), exp_bit(1, a), exp_bit(0, a)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic host_write(int c, int k, logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_ch = 2'(c); host_word = 6'(k); host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(int c, int k, output logic [15:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_ch = 2'(c); host_word = 6'(k);
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  // clear, then follow the internal counter for n cycles at period per
  task automatic run_scan(int rsel, int per, int n, string req);
    @(negedge clk);
    src_ext = 1'b0; rate_sel = 3'(rsel); cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    check("R6", 32'(scan_addr), 32'd0);
    for (int t = 1; t <= n; t++) begin
      logic [2:0] ep;
      @(negedge clk);
      ep = 3'b000;
      if (t >= per + 1 && (t - 1) % per == 0) ep = exp_pulse(((t - 1) / per) % 1024);
      check(req, {19'd0, pulse_out, scan_addr}, {19'd0, ep, 10'((t / per) % 1024)});
    end
  endtask

  task automatic ext_step(int a, logic changed);
    @(negedge clk);
    ext_addr = 10'(a);
    @(negedge clk);
    check("R7", 32'(scan_addr), 32'(a));
    @(negedge clk);
    check("R7", 32'(pulse_out), changed ? 32'(exp_pulse(a)) : 32'd0);
    @(negedge clk);
    check("R8", 32'(pulse_out), 32'd0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", 32'(scan_addr), 32'd0);
    check("R1", 32'(pulse_out), 32'd0);
    check("R1", 32'(host_rdata), 32'd0);
    host_read(1, 9, rd);
    check("R1", 32'(rd), 32'd0);

    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 64; k++) host_write(c, k, pat(c, k));
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 64; k++) begin
        host_read(c, k, rd);
        check("R2", 32'(rd), 32'(pat(c, k)));
      end

    host_write(3, 5, 16'hFFFF);
    for (int c = 0; c < 3; c++) begin
      host_read(c, 5, rd);
      check("R3", 32'(rd), 32'(pat(c, 5)));
    end
    host_read(3, 5, rd);
    check("R3", 32'(rd), 32'd0);

    run_scan(5, 1, 2100, "R4");
    run_scan(4, 10, 320, "R5");
    run_scan(2, 1000, 3010, "R5");
    run_scan(7, 1, 40, "R5");

    @(negedge clk);
    src_ext = 1'b1;
    ext_step(0, 1'b0);
    for (int i = 1; i < 40; i++) ext_step((i * 331) % 1024, 1'b1);
    ext_step(((39 * 331) % 1024), 1'b0);
    ext_step(1023, 1'b1);
    ext_step(16, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule